// File: doc/BRIEF.md
# 8-bit PWM timer with buffered duty

This block is an up-counting 8-bit timer that turns two compare values into a pulse-width waveform. The period compare value fixes where the count wraps back to 00H. At that point the output switches to its active level and a one-clock match interrupt is raised. The duty compare value fixes the count at which the output drops back to its inactive level. The count advances only on cycles where the count-clock enable pulse is high, so a prescaler outside the block sets the rate.

A duty write made while the timer runs does not take effect at once. It is parked in a holding register and is moved into the working duty register only when the count meets the old duty value. For the move to happen, that match must come at least three count ticks after the write. A move that misses this window stays pending and is tried again at a later match. Period writes, and duty writes made while the timer is stopped, take effect directly. A polarity input selects whether the active level is high or low.

Top module: `pwm8_duty_timer`

## Requirements
- R1: After reset the count is 00H, the interrupt is low, the output is at its inactive level, both compare values are 00H and no duty move is pending.
- R2: After the run input rises, the first count tick is swallowed and the count stays at 00H. Each later tick raises the count by one. Cycles without a tick leave the count unchanged.
- R3: From the moment counting starts until the first period match, the output stays at its inactive level.
- R4: On a tick where the count equals the period value, the count returns to 00H and the output goes active. The interrupt is high for exactly the clock cycle after that tick edge.
- R5: On a tick where the count equals the working duty value but not the period value, the output goes inactive, the count still advances and no interrupt occurs. If both values match on the same tick, the period match wins.
- R6: A duty write while running goes to a holding register and leaves the working duty value unchanged. The held value replaces it at a tick where the count equals the old working duty value.
- R7: The move happens at a duty-match tick only if that tick is the third or later tick after the write cycle. A tick in the write cycle itself is not counted.
- R8: A move that misses its window stays pending. It completes at the next duty-match tick, which by then satisfies the rule.
- R9: Period writes take effect at once. A duty write while stopped loads the working duty value directly and cancels any pending move.
- R10: Lowering the run input clears the count to 00H, holds the interrupt low and forces the output inactive. The next start swallows its first tick again.
- R11: With polarity input 0 the active level is high. With polarity input 1 the active level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count-clock enable pulse |
| run_en | input | 1 | Timer run control |
| inv_pol | input | 1 | Output polarity, 1 = active low |
| period_we | input | 1 | Period compare write strobe |
| period_wdata | input | 8 | Period compare write value |
| duty_we | input | 1 | Duty compare write strobe |
| duty_wdata | input | 8 | Duty compare write value |
| pwm_out | output | 1 | PWM waveform |
| match_irq | output | 1 | Period match interrupt pulse |
| count_val | output | 8 | Current count |

## Verification
The hardest case to reach is a duty write that lands just before the old duty match. It must arrive two ticks early, so that the move is refused and carried into the next period, or exactly three ticks early, so that the move is just accepted. The bench steers the timer with its own reference state. It issues ticks until its predicted count sits at the chosen distance from the duty value, and only then makes the write. The scoreboard then shows in which period the output edge moves.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int unsigned PWM8_CW_DEF  = 8;
  localparam int unsigned PWM8_GAP_DEF = 3;

  typedef struct packed {
    logic period_hit;
    logic duty_hit;
  } pwm8_hit_t;
endpackage

// File: rtl/pwm8_count_unit.sv
module pwm8_count_unit
  import pwm8_pkg::*;
#(
  parameter int unsigned CW = PWM8_CW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] duty,
  output logic [CW-1:0] count,
  output logic          step,
  output pwm8_hit_t     hit
);
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    hit.period_hit = (cnt_q == period);
    hit.duty_hit   = (cnt_q == duty);
    step           = run & armed_q & tick;
  end

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (!run) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (tick) begin
      if (!armed_q) begin
        armed_d = 1'b1;
      end else if (hit.period_hit) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/pwm8_duty_buf.sv
module pwm8_duty_buf
  import pwm8_pkg::*;
#(
  parameter int unsigned CW  = PWM8_CW_DEF,
  parameter int unsigned GAP = PWM8_GAP_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic          duty_hit,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] duty_act
);
  localparam int unsigned AW = $clog2(GAP + 1);
  localparam logic [AW-1:0] AGE_OK  = AW'(GAP - 1);
  localparam logic [AW-1:0] AGE_TOP = {AW{1'b1}};

  logic [CW-1:0] act_q, act_d;
  logic [CW-1:0] hold_q, hold_d;
  logic          pend_q, pend_d;
  logic [AW-1:0] age_q, age_d;

  always_comb begin
    act_d  = act_q;
    hold_d = hold_q;
    pend_d = pend_q;
    age_d  = age_q;
    if (wr_en) begin
      hold_d = wr_data;
      if (run) begin
        pend_d = 1'b1;
        age_d  = '0;
      end else begin
        act_d  = wr_data;
        pend_d = 1'b0;
      end
    end else if (step) begin
      if (age_q != AGE_TOP) begin
        age_d = age_q + 1'b1;
      end
      if (duty_hit && pend_q && (age_q >= AGE_OK)) begin
        act_d  = hold_q;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
      age_q  <= '0;
    end else begin
      act_q  <= act_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
      age_q  <= age_d;
    end
  end

  assign duty_act = act_q;
endmodule

// File: rtl/pwm8_out_stage.sv
module pwm8_out_stage
  import pwm8_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      step,
  input  pwm8_hit_t hit,
  input  logic      inv_pol,
  output logic      pwm_out,
  output logic      irq
);
  logic lvl_q, lvl_d;
  logic irq_q, irq_d;

  always_comb begin
    lvl_d = lvl_q;
    irq_d = 1'b0;
    if (!run) begin
      lvl_d = 1'b0;
    end else if (step) begin
      if (hit.period_hit) begin
        lvl_d = 1'b1;
        irq_d = 1'b1;
      end else if (hit.duty_hit) begin
        lvl_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      irq_q <= irq_d;
    end
  end

  assign pwm_out = lvl_q ^ inv_pol;
  assign irq     = irq_q;
endmodule

// File: rtl/pwm8_duty_timer.sv
module pwm8_duty_timer
  import pwm8_pkg::*;
#(
  parameter int unsigned CW  = PWM8_CW_DEF,
  parameter int unsigned GAP = PWM8_GAP_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic          run_en,
  input  logic          inv_pol,
  input  logic          period_we,
  input  logic [CW-1:0] period_wdata,
  input  logic          duty_we,
  input  logic [CW-1:0] duty_wdata,
  output logic          pwm_out,
  output logic          match_irq,
  output logic [CW-1:0] count_val
);
  logic [1:0]    rsync_q;
  logic          rst_s;
  logic [CW-1:0] per_q, per_d;
  logic [CW-1:0] duty_act;
  logic          step;
  pwm8_hit_t     hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  always_comb begin
    per_d = per_q;
    if (period_we) per_d = period_wdata;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) per_q <= '0;
    else        per_q <= per_d;
  end

  pwm8_count_unit #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_s),
    .tick   (cnt_tick),
    .run    (run_en),
    .period (per_q),
    .duty   (duty_act),
    .count  (count_val),
    .step   (step),
    .hit    (hit)
  );

  pwm8_duty_buf #(.CW(CW), .GAP(GAP)) u_duty (
    .clk      (clk),
    .rst_n    (rst_s),
    .run      (run_en),
    .step     (step),
    .duty_hit (hit.duty_hit),
    .wr_en    (duty_we),
    .wr_data  (duty_wdata),
    .duty_act (duty_act)
  );

  pwm8_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_s),
    .run     (run_en),
    .step    (step),
    .hit     (hit),
    .inv_pol (inv_pol),
    .pwm_out (pwm_out),
    .irq     (match_irq)
  );
endmodule

// File: rtl/pwm8_duty_timer_chk.sv
module pwm8_duty_timer_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_s,
  input logic          cnt_tick,
  input logic          run_en,
  input logic          inv_pol,
  input logic [CW-1:0] count_val,
  input logic          match_irq,
  input logic          pwm_out,
  input logic [CW-1:0] duty_act
);
  assert_tick_gate_R2: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(run_en) && !$past(cnt_tick)) |-> $stable(count_val));

  assert_irq_wrap_R4: assert property (@(posedge clk) disable iff (!rst_s)
    match_irq |-> (count_val == '0) && (pwm_out != inv_pol));

  assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_s)
    match_irq |-> ($past(cnt_tick) && $past(run_en)));

  assert_swap_point_R6: assert property (@(posedge clk) disable iff (!rst_s)
    ($past(run_en) && !$stable(duty_act)) |->
      ($past(count_val) == $past(duty_act)) && $past(cnt_tick));

  assert_stopped_R10: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(run_en) |-> (count_val == '0) && !match_irq && (pwm_out == inv_pol));
endmodule

bind pwm8_duty_timer pwm8_duty_timer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .cnt_tick  (cnt_tick),
  .run_en    (run_en),
  .inv_pol   (inv_pol),
  .count_val (count_val),
  .match_irq (match_irq),
  .pwm_out   (pwm_out),
  .duty_act  (duty_act)
);

// File: tb/pwm8_duty_timer_test.sv
module pwm8_duty_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_tick, run_en, inv_pol;
  logic       period_we, duty_we;
  logic [7:0] period_wdata, duty_wdata;
  logic       pwm_out, match_irq;
  logic [7:0] count_val;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // expected-item queues
  int    q_cnt[$];
  int    q_pwm[$];
  int    q_irq[$];
  string q_tag[$];
  logic  due;

  // reference state
  int m_cnt, m_per, m_duty, m_hold, m_age;
  bit m_run, m_arm, m_pend, m_act, m_pol;

  always #4 clk = ~clk;

  pwm8_duty_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .run_en(run_en),
    .inv_pol(inv_pol), .period_we(period_we), .period_wdata(period_wdata),
    .duty_we(duty_we), .duty_wdata(duty_wdata), .pwm_out(pwm_out),
    .match_irq(match_irq), .count_val(count_val)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) due <= cnt_tick;

  // monitor
  always @(negedge clk) begin
    if (due === 1'b1 && q_cnt.size() > 0) begin
      string t;
      int ec, ep, ei;
      ec = q_cnt.pop_front();
      ep = q_pwm.pop_front();
      ei = q_irq.pop_front();
      t  = q_tag.pop_front();
      n_cmp++;
      if (count_val != ec[7:0] || pwm_out != ep[0] || match_irq != ei[0]) begin
        n_bad++;
        $display("FAIL %s actual cnt=%0h pwm=%0b irq=%0b expected cnt=%0h pwm=%0b irq=%0b",
                 t, count_val, pwm_out, match_irq, ec, ep, ei);
      end
    end else if (rst_n === 1'b1 && due === 1'b0) begin
      chk("R4 pulse width", int'(match_irq), 0);
    end
  end

  task automatic tick_once(string tag);
    bit hp, hd;
    int irq_e;
    @(negedge clk);
    cnt_tick = 1'b1;
    irq_e = 0;
    if (!m_arm) begin
      m_arm = 1;
    end else begin
      hp = (m_cnt == m_per);
      hd = (m_cnt == m_duty);
      if (m_pend && hd && m_age >= 2) begin
        m_duty = m_hold;
        m_pend = 0;
      end
      if (m_age < 3) m_age++;
      if (hp) begin
        m_cnt = 0; m_act = 1; irq_e = 1;
      end else begin
        if (hd) m_act = 0;
        m_cnt = (m_cnt + 1) % 256;
      end
    end
    q_cnt.push_back(m_cnt);
    q_pwm.push_back(int'(m_act ^ m_pol));
    q_irq.push_back(irq_e);
    q_tag.push_back(tag);
    @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic run_ticks(int n, string tag);
    for (int i = 0; i < n; i++) tick_once(tag);
  endtask

  task automatic run_until(int target, string tag);
    while (m_cnt != target) tick_once(tag);
  endtask

  task automatic write_period(int v);
    @(negedge clk);
    period_we = 1'b1; period_wdata = v[7:0];
    m_per = v;
    @(negedge clk);
    period_we = 1'b0;
  endtask

  task automatic write_duty(int v);
    @(negedge clk);
    duty_we = 1'b1; duty_wdata = v[7:0];
    m_hold = v;
    if (m_run) begin m_pend = 1; m_age = 0; end
    else begin m_duty = v; m_pend = 0; end
    @(negedge clk);
    duty_we = 1'b0;
  endtask

  task automatic start();
    @(negedge clk);
    run_en = 1'b1; m_run = 1;
  endtask

  task automatic stop_and_check();
    @(negedge clk);
    run_en = 1'b0;
    m_run = 0; m_arm = 0; m_cnt = 0; m_act = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 count after stop", int'(count_val), 0);
    chk("R10 irq after stop", int'(match_irq), 0);
    chk("R10 output after stop", int'(pwm_out), int'(m_pol));
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    wrap_up();
  end

  initial begin
    rst_n = 1'b0; cnt_tick = 1'b0; run_en = 1'b0; inv_pol = 1'b0;
    period_we = 1'b0; duty_we = 1'b0; period_wdata = '0; duty_wdata = '0;
    m_cnt = 0; m_per = 0; m_duty = 0; m_hold = 0; m_age = 0;
    m_run = 0; m_arm = 0; m_pend = 0; m_act = 0; m_pol = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 count", int'(count_val), 0);
    chk("R1 irq", int'(match_irq), 0);
    chk("R1 output", int'(pwm_out), 0);

    // R9: writes while stopped take effect directly
    write_period(8'hA5);
    write_duty(8'h02);
    start();
    tick_once("R2 first tick masked");
    run_ticks(3, "R2 counting");
    run_until(8'hA5, "R3 inactive before first wrap");
    tick_once("R4 period wrap");
    run_ticks(5, "R5 duty edge");

    // R6: early write, moved at the old-value match in the next period
    run_until(8'h10, "R6 run");
    write_duty(8'h03);
    run_until(8'hA5, "R6 old duty still active");
    run_ticks(8, "R6 move at old match");
    run_until(8'hA5, "R6 run");
    run_ticks(8, "R6 new duty edge");

    // R7/R8: write two ticks before the match, move refused, retried later
    run_until(8'hA5, "R7 run");
    run_ticks(3, "R7 run");
    write_duty(8'h05);
    run_ticks(4, "R7 late write not moved");
    run_until(8'hA5, "R8 run");
    run_ticks(8, "R8 retried move");
    run_until(8'hA5, "R8 run");
    run_ticks(8, "R8 edge at new value");

    // R7: write exactly three ticks before the match, move accepted
    run_until(8'hA5, "R7 run");
    run_ticks(4, "R7 run");
    write_duty(8'h07);
    run_ticks(6, "R7 boundary move");
    run_until(8'hA5, "R7 run");
    run_ticks(10, "R7 new edge");

    stop_and_check();

    // R11: inverted polarity, shorter period
    inv_pol = 1'b1; m_pol = 1;
    @(negedge clk);
    chk("R11 inactive high when inverted", int'(pwm_out), 1);
    write_period(8'h10);
    start();
    run_ticks(40, "R11 inverted waveform");

    // R9: period change while running takes effect at once
    write_period(8'h0C);
    run_ticks(30, "R9 period change live");

    // R10: stop while output active, restart masks first tick
    run_until(8'h0C, "R10 run");
    run_ticks(3, "R10 run");
    stop_and_check();
    start();
    tick_once("R10 masked after restart");
    run_ticks(20, "R10 restart");
    stop_and_check();

    // R5: duty equal to period, wrap wins
    inv_pol = 1'b0; m_pol = 0;
    write_period(8'h08);
    write_duty(8'h08);
    start();
    run_ticks(30, "R5 period priority");
    stop_and_check();

    repeat (4) @(negedge clk);
    wrap_up();
  end
endmodule